// File: doc/BRIEF.md
# H-Blank Paced Video Memory Copy Engine

This block moves data from system memory into video memory in fixed 16-byte chunks. Software programs a source pointer and a destination pointer. It then writes one control byte. That byte selects the pacing mode and the number of chunks, and the same write starts the copy. In general mode every chunk follows the previous one with only one idle cycle between them. In h-blank mode the engine moves exactly one chunk for each horizontal-blank pulse from the display timing logic, so the copy can run while the picture is being drawn.

The control byte also works as the status and abort register. While a copy runs, its top bit reads as zero and its low seven bits hold the number of chunks left minus one. The count steps down after each chunk, and the copy ends when the count wraps past zero. A finished engine reads 0xFF. A write with the top bit clear cancels a running copy and leaves the remaining count readable. Software can use this to stop an h-blank copy after the chunks it actually needs. Each chunk is read one byte per cycle from a combinational memory read port and written in the same cycle to the video memory write port.

Top module: `vram_chunk_dma`

## Requirements
- R1: Out of reset the control byte (register index 4) reads 0xFF, `busy` and `vramWrEn` are low, and both pointers read zero.
- R2: Writing the control byte with bit 7 = 0 while idle, with color mode on, starts a general-mode copy of (bits[6:0] + 1) chunks of 16 bytes. Each byte read at source address S+i is written to destination D+i, one byte per cycle, with consecutive write addresses inside a chunk. `busy` is high only while a chunk is being written.
- R3: Writing the control byte with bit 7 = 1 starts an h-blank-mode copy. No byte moves before the first `hblank` pulse, and each pulse moves exactly one 16-byte chunk.
- R4: While a copy is in progress the control byte reads with bit 7 = 0 and bits[6:0] = chunks remaining minus one. This value decrements by one after each chunk.
- R5: When the last chunk completes (the count wraps from 0x00), the control byte reads 0xFF, the engine goes idle, and later `hblank` pulses move nothing.
- R6: Writing the control byte with bit 7 = 0 while a copy is active aborts it. The control byte then reads {1, remaining bits[6:0]}, and no further bytes are written.
- R7: Both pointers advance by 16 after each chunk. A carry out of the low byte increments the high byte. The low 4 bits of each pointer always read as zero (registers 0/1 source high/low, 2/3 destination high/low).
- R8: With `colorEn` low, writes to the control byte have no effect: it keeps reading its old value and nothing is copied.
- R9: An `hblank` pulse that arrives while a chunk is being written is latched. It yields exactly one more chunk after the current one.
- R10: A control write in the same cycle as a chunk's final byte takes priority. The decrement and the pointer advance of that chunk are not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| colorEn | input | 1 | Color mode enable; gates control writes |
| hblank | input | 1 | One-cycle horizontal-blank pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index (0 src hi, 1 src lo, 2 dst hi, 3 dst lo, 4 control) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Combinational read of the selected register |
| memRdEn | output | 1 | System memory read enable |
| memRdAddr | output | 16 | System memory read address |
| memRdData | input | 8 | System memory read data, valid in the same cycle |
| vramWrEn | output | 1 | Video memory write enable |
| vramWrAddr | output | 16 | Video memory write address |
| vramWrData | output | 8 | Video memory write data |
| busy | output | 1 | High while a chunk is being written |

## Verification
A wrong chunk counter shows up at the control byte within one cycle of a chunk's end. It shows as a skipped or doubled decrement, or as a missed 0xFF on the final wrap. It also shows as one chunk too many or too few at the write port. A wrong pacing flag is visible as 16 stray writes within about 17 cycles of a start or an abort, or as a missing chunk after a pulse that arrived mid-copy. A pointer error shows at the first write of the next chunk as a broken address sequence, or on the readback of the pointer registers.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  parameter int CHUNK_LOG2  = 4;
  parameter int CHUNK_BYTES = 1 << CHUNK_LOG2;

  localparam logic [2:0] REG_SRC_HI = 3'd0;
  localparam logic [2:0] REG_SRC_LO = 3'd1;
  localparam logic [2:0] REG_DST_HI = 3'd2;
  localparam logic [2:0] REG_DST_LO = 3'd3;
  localparam logic [2:0] REG_CTRL   = 3'd4;

  typedef struct packed {
    logic                  copyEn;
    logic                  advance;
    logic [CHUNK_LOG2-1:0] byteIdx;
  } vdmaStrobes_t;
endpackage

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
  import vdma_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              colorEn,
  input  logic              hblank,
  input  logic              ctrlWr,
  input  logic [DATA_W-1:0] wrData,
  output vdmaStrobes_t      strobes,
  output logic [DATA_W-1:0] ctrlStatus,
  output logic              xferActive,
  output logic              busy
);
  localparam int CNT_W = DATA_W - 1;

  logic                  active, hbMode, ready, copying;
  logic [CHUNK_LOG2-1:0] byteIdx;
  logic [DATA_W-1:0]     ctrlReg;
  logic                  ctrlAccept, lastByte, finalChunk, launch, readyNext;

  assign ctrlAccept = ctrlWr && colorEn;
  assign lastByte   = copying && (byteIdx == {CHUNK_LOG2{1'b1}});
  assign finalChunk = lastByte && (ctrlReg == '0);
  assign launch     = active && !copying && (!hbMode || ready);

  // pulse wins over consumption, so a blank seen during a copy is kept
  always_comb begin
    readyNext = ready;
    if (launch) readyNext = 1'b0;
    if (active && hbMode && hblank) readyNext = 1'b1;
    if (finalChunk || !active) readyNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      hbMode  <= 1'b0;
      ready   <= 1'b0;
      copying <= 1'b0;
      byteIdx <= '0;
      ctrlReg <= '1;
    end else if (ctrlAccept) begin
      copying <= 1'b0;
      byteIdx <= '0;
      ready   <= 1'b0;
      if (wrData[DATA_W-1]) begin
        active  <= 1'b1;
        hbMode  <= 1'b1;
        ctrlReg <= {1'b0, wrData[CNT_W-1:0]};
      end else if (active) begin
        active  <= 1'b0;
        hbMode  <= 1'b0;
        ctrlReg <= {1'b1, ctrlReg[CNT_W-1:0]};
      end else begin
        active  <= 1'b1;
        hbMode  <= 1'b0;
        ctrlReg <= {1'b0, wrData[CNT_W-1:0]};
      end
    end else begin
      ready <= readyNext;
      if (launch) begin
        copying <= 1'b1;
        byteIdx <= '0;
      end else if (copying) begin
        byteIdx <= byteIdx + 1'b1;
        if (lastByte) begin
          copying <= 1'b0;
          ctrlReg <= ctrlReg - 1'b1;
          if (finalChunk) begin
            active <= 1'b0;
            hbMode <= 1'b0;
          end
        end
      end
    end
  end

  assign strobes.copyEn  = copying;
  assign strobes.advance = lastByte && !ctrlAccept;
  assign strobes.byteIdx = byteIdx;
  assign ctrlStatus      = ctrlReg;
  assign xferActive      = active;
  assign busy            = copying;
endmodule

// File: rtl/vdma_path.sv
module vdma_path
  import vdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        hiWr,
  input  logic [1:0]        loWr,
  input  logic [DATA_W-1:0] wrData,
  input  vdmaStrobes_t      strobes,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] vramWrAddr
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [DATA_W-1:0] LO_MASK = {DATA_W{1'b1}} << CHUNK_LOG2;

  logic [1:0][ADDR_W-1:0] ptr;
  logic [1:0][ADDR_W-1:0] offAddr;

  // index 0 = source pointer, index 1 = destination pointer
  for (genvar g = 0; g < 2; g++) begin : g_ptr
    logic [ADDR_W-1:0] ptrQ;
    always_ff @(posedge clk) begin
      if (!rstN)
        ptrQ <= '0;
      else if (hiWr[g])
        ptrQ[ADDR_W-1:DATA_W] <= wrData[HI_W-1:0];
      else if (loWr[g])
        ptrQ[DATA_W-1:0] <= wrData & LO_MASK;
      else if (strobes.advance)
        ptrQ <= ptrQ + ADDR_W'(CHUNK_BYTES);
    end
    assign ptr[g]     = ptrQ;
    assign offAddr[g] = ptrQ | ADDR_W'(strobes.byteIdx);
  end

  assign srcAddr    = ptr[0];
  assign dstAddr    = ptr[1];
  assign memRdAddr  = offAddr[0];
  assign vramWrAddr = offAddr[1];
endmodule

// File: rtl/vram_chunk_dma.sv
module vram_chunk_dma
  import vdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              colorEn,
  input  logic              hblank,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              vramWrEn,
  output logic [ADDR_W-1:0] vramWrAddr,
  output logic [DATA_W-1:0] vramWrData,
  output logic              busy
);
  localparam int HI_W = ADDR_W - DATA_W;

  vdmaStrobes_t      strobes;
  logic [DATA_W-1:0] ctrlStatus;
  logic              xferActive;
  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [1:0]        hiWr, loWr;
  logic              ctrlWr;

  assign hiWr[0] = regWrEn && (regAddr == REG_SRC_HI);
  assign loWr[0] = regWrEn && (regAddr == REG_SRC_LO);
  assign hiWr[1] = regWrEn && (regAddr == REG_DST_HI);
  assign loWr[1] = regWrEn && (regAddr == REG_DST_LO);
  assign ctrlWr  = regWrEn && (regAddr == REG_CTRL);

  vdma_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .colorEn(colorEn), .hblank(hblank),
    .ctrlWr(ctrlWr), .wrData(regWrData), .strobes(strobes),
    .ctrlStatus(ctrlStatus), .xferActive(xferActive), .busy(busy)
  );

  vdma_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .hiWr(hiWr), .loWr(loWr), .wrData(regWrData),
    .strobes(strobes), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .memRdAddr(memRdAddr), .vramWrAddr(vramWrAddr)
  );

  always_comb begin
    case (regAddr)
      REG_SRC_HI: regRdData = DATA_W'(srcAddr[ADDR_W-1:DATA_W]);
      REG_SRC_LO: regRdData = srcAddr[DATA_W-1:0];
      REG_DST_HI: regRdData = DATA_W'(dstAddr[ADDR_W-1:DATA_W]);
      REG_DST_LO: regRdData = dstAddr[DATA_W-1:0];
      REG_CTRL:   regRdData = ctrlStatus;
      default:    regRdData = '0;
    endcase
  end

  assign memRdEn    = strobes.copyEn;
  assign vramWrEn   = strobes.copyEn;
  assign vramWrData = memRdData;

  logic [HI_W-1:0] unusedHi;
  assign unusedHi = '0;
endmodule

// File: rtl/vram_chunk_dma_chk.sv
module vram_chunk_dma_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              colorEn,
  input logic              regWrEn,
  input logic [2:0]        regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              busy,
  input logic              vramWrEn,
  input logic [ADDR_W-1:0] vramWrAddr,
  input logic [DATA_W-1:0] ctrlStatus,
  input logic              xferActive,
  input logic [ADDR_W-1:0] dstAddr
);
  logic ctrlWrOk;
  assign ctrlWrOk = regWrEn && (regAddr == 3'd4) && colorEn;

  assert_write_contig_R2: assert property (@(posedge clk) disable iff (!rstN)
    vramWrEn && $past(vramWrEn) |-> vramWrAddr == $past(vramWrAddr) + 1'b1);

  assert_busy_status_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctrlStatus[DATA_W-1]);

  assert_chunk_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) && !$past(ctrlWrOk) |-> ctrlStatus == $past(ctrlStatus) - 1'b1);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStatus == {DATA_W{1'b1}} |-> !busy && !xferActive);

  assert_abort_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrlWrOk && !regWrData[DATA_W-1] && xferActive) |-> ctrlStatus[DATA_W-1] && !xferActive);

  assert_dst_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) && !$past(regWrEn) |-> dstAddr == $past(dstAddr) + ADDR_W'(16));

  assert_color_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(colorEn) && !$past(xferActive) |-> !xferActive);
endmodule

bind vram_chunk_dma vram_chunk_dma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .colorEn(colorEn), .regWrEn(regWrEn),
  .regAddr(regAddr), .regWrData(regWrData), .busy(busy), .vramWrEn(vramWrEn),
  .vramWrAddr(vramWrAddr), .ctrlStatus(ctrlStatus), .xferActive(xferActive),
  .dstAddr(dstAddr)
);

// File: tb/vram_chunk_dma_tb.sv
`timescale 1ns/1ps
module vram_chunk_dma_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        colorEn = 1'b1;
  logic        hblank = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [7:0]  regWrData = 8'd0;
  logic [7:0]  regRdData;
  logic        memRdEn;
  logic [15:0] memRdAddr;
  logic [7:0]  memRdData;
  logic        vramWrEn;
  logic [15:0] vramWrAddr;
  logic [7:0]  vramWrData;
  logic        busy;

  int checks = 0;
  int errors = 0;
  int writeCount = 0;
  logic [15:0] expSrc = 16'h0, expDst = 16'h0;

  always #2 clk = ~clk;

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ {a[10:8], a[15:11]} ^ 8'h5A;
  endfunction

  assign memRdData = memByte(memRdAddr);

  vram_chunk_dma u_dut (
    .clk(clk), .rstN(rstN), .colorEn(colorEn), .hblank(hblank),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdData(memRdData), .vramWrEn(vramWrEn), .vramWrAddr(vramWrAddr),
    .vramWrData(vramWrData), .busy(busy)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // write monitor: address sequence and data per R2/R7
  always @(negedge clk) begin
    if (rstN && vramWrEn) begin
      writeCount++;
      check(vramWrAddr == expDst && memRdAddr == expSrc && vramWrData == memByte(expSrc) && busy,
            "R2 write addr/data", {vramWrAddr, vramWrData}, {expDst, memByte(expSrc)});
      expDst = expDst + 16'd1;
      expSrc = expSrc + 16'd1;
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic setPtrs(input logic [15:0] s, input logic [15:0] d);
    regWrite(3'd0, s[15:8]); regWrite(3'd1, s[7:0]);
    regWrite(3'd2, d[15:8]); regWrite(3'd3, d[7:0]);
    expSrc = {s[15:4], 4'h0};
    expDst = {d[15:4], 4'h0};
  endtask

  task automatic pulseHb();
    @(negedge clk); hblank = 1'b1;
    @(negedge clk); hblank = 1'b0;
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0x1 expected=0x0");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [7:0] rd;
    int base;
    void'($urandom(32'd20240611));
    cycles(3);
    rstN = 1'b1;
    cycles(1);

    // R1 reset state
    regRead(3'd4, rd); check(rd == 8'hFF, "R1 ctrl reset", rd, 8'hFF);
    check(!busy && !vramWrEn, "R1 idle", busy, 0);
    regRead(3'd2, rd); check(rd == 8'h00, "R1 dst hi reset", rd, 0);

    // R8 color gate
    colorEn = 1'b0;
    base = writeCount;
    regWrite(3'd4, 8'h02);
    cycles(60);
    check(writeCount == base, "R8 no copy without color", writeCount - base, 0);
    regRead(3'd4, rd); check(rd == 8'hFF, "R8 ctrl unchanged", rd, 8'hFF);
    colorEn = 1'b1;

    // R2/R4/R5/R7 general mode with destination carry
    setPtrs(16'h1234, 16'h80F7);
    regRead(3'd1, rd); check(rd == 8'h30, "R7 low nibble zero", rd, 8'h30);
    base = writeCount;
    regWrite(3'd4, 8'h02);
    regRead(3'd4, rd); check(rd == 8'h02, "R4 active status", rd, 8'h02);
    cycles(80);
    check(writeCount - base == 48, "R2 general length", writeCount - base, 48);
    regRead(3'd4, rd); check(rd == 8'hFF, "R5 done reads FF", rd, 8'hFF);
    regRead(3'd2, rd); check(rd == 8'h81, "R7 dst carry hi", rd, 8'h81);
    regRead(3'd3, rd); check(rd == 8'h20, "R7 dst lo", rd, 8'h20);
    regRead(3'd1, rd); check(rd == 8'h60, "R7 src advanced", rd, 8'h60);

    // R3/R4/R9/R6 h-blank mode
    setPtrs(16'h4000, 16'h9000);
    base = writeCount;
    regWrite(3'd4, 8'h83);
    cycles(40);
    check(writeCount == base, "R3 no copy before blank", writeCount - base, 0);
    regRead(3'd4, rd); check(rd == 8'h03, "R4 hb status", rd, 8'h03);
    pulseHb(); cycles(30);
    check(writeCount - base == 16, "R3 one chunk per blank", writeCount - base, 16);
    regRead(3'd4, rd); check(rd == 8'h02, "R4 decrement", rd, 8'h02);
    base = writeCount;
    pulseHb(); cycles(5); pulseHb(); cycles(45);
    check(writeCount - base == 32, "R9 mid-chunk blank latched", writeCount - base, 32);
    regRead(3'd4, rd); check(rd == 8'h00, "R4 count zero", rd, 8'h00);
    regWrite(3'd4, 8'h00);
    regRead(3'd4, rd); check(rd == 8'h80, "R6 abort status", rd, 8'h80);
    base = writeCount;
    pulseHb(); cycles(30);
    check(writeCount == base, "R6 no copy after abort", writeCount - base, 0);

    // R5 h-blank to completion
    setPtrs(16'h2200, 16'h8800);
    base = writeCount;
    regWrite(3'd4, 8'h81);
    pulseHb(); cycles(25); pulseHb(); cycles(25);
    regRead(3'd4, rd); check(rd == 8'hFF, "R5 hb wrap to FF", rd, 8'hFF);
    pulseHb(); cycles(30);
    check(writeCount - base == 32, "R5 no copy after done", writeCount - base, 32);

    // R10 control write in the final-byte cycle wins
    setPtrs(16'h3000, 16'h8400);
    regWrite(3'd4, 8'h05);
    forever begin
      @(negedge clk);
      if (vramWrEn && vramWrAddr[3:0] == 4'hF) break;
    end
    regWrEn = 1'b1; regAddr = 3'd4; regWrData = 8'h00;
    @(negedge clk); regWrEn = 1'b0;
    regRead(3'd4, rd); check(rd == 8'h85, "R10 no decrement on write", rd, 8'h85);
    regRead(3'd3, rd); check(rd == 8'h00, "R10 no advance on write", rd, 8'h00);
    base = writeCount;
    cycles(40);
    check(writeCount == base, "R6 abort stops", writeCount - base, 0);

    // random general-mode runs
    for (int it = 0; it < 6; it++) begin
      logic [15:0] s, d;
      int len;
      s = 16'($urandom); d = 16'($urandom); len = int'($urandom % 4);
      setPtrs(s, d);
      base = writeCount;
      regWrite(3'd4, 8'(len));
      cycles((len + 1) * 17 + 10);
      check(writeCount - base == (len + 1) * 16, "R2 random length", writeCount - base, (len + 1) * 16);
      regRead(3'd4, rd); check(rd == 8'hFF, "R5 random done", rd, 8'hFF);
    end

    // random h-blank runs with spaced pulses
    for (int it = 0; it < 4; it++) begin
      logic [15:0] s, d;
      int len;
      s = 16'($urandom); d = 16'($urandom); len = int'($urandom % 3);
      setPtrs(s, d);
      base = writeCount;
      regWrite(3'd4, 8'h80 | 8'(len));
      for (int p = 0; p <= len; p++) begin
        cycles(int'($urandom % 8));
        pulseHb(); cycles(20);
        check(writeCount - base == (p + 1) * 16, "R3 random paced", writeCount - base, (p + 1) * 16);
      end
      regRead(3'd4, rd); check(rd == 8'hFF, "R5 random hb done", rd, 8'hFF);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule